// File: doc/BRIEF.md
# Fault-Aware Cache Column Remapper

This block sits beside a direct-mapped cache data array that stores four blocks in every row. Self-test finds the faulty blocks before normal use. Their positions go into a small fault store that keeps one bit per block, and that store is loaded through a write port. During normal accesses the row part of the cache index reads the fault word for that row in the same cycle as the data array. Combinational logic then rewrites the column address that drives the column multiplexer, so a faulty block is never selected.

A faulty block is steered to a healthy block in the same row. Faulty blocks are counted in ascending order and healthy blocks are dealt out to them in ascending order. Once every healthy block has been used, the count wraps back to the first healthy block. This spreads the redirected traffic across the healthy blocks that remain. Because several indices can then land on one physical block, the block passes the original column bits on, so the tag can be widened with them. A row with no healthy block at all is flagged as unusable.

The default sizes are a 32 KB cache with 32-byte blocks and four blocks per row. That gives 256 rows and a 1 Kbit fault store.

Top module: `col_remap`

## Requirements
- R1: Synchronous active-low reset clears every fault word. After reset every row maps each column to itself and no row is flagged dead.
- R2: When the fault bit of the requested block is clear, `phys_col` equals `lk_col`.
- R3: Bit i of a fault word flags block i, so block 0 is the least significant bit. A write with `cfg_we` high stores `cfg_wdata` into row `cfg_row` at the rising clock edge. A lookup of that row in the same cycle still sees the old word, and a lookup from the next cycle on sees the new word.
- R4: Take a requested block that is faulty. Let k be the number of faulty blocks below it, and let H be the number of healthy blocks in the row, with H greater than 0. The block is then steered to the healthy block whose ascending rank among the healthy blocks is k mod H.
- R5: With only block 2 faulty (`cfg_wdata` = 4'b0100), columns 0, 1, 2 and 3 map to 0, 1, 0 and 3.
- R6: With blocks 1 and 2 faulty (4'b0110), columns 0, 1, 2 and 3 map to 0, 0, 3 and 3.
- R7: With only block 3 healthy (4'b0111), every column maps to 3.
- R8: With all four blocks faulty (4'b1111), `row_dead` is 1 and `phys_col` equals `lk_col`. Otherwise `row_dead` is 0.
- R9: Whenever `row_dead` is 0, the block chosen by `phys_col` is healthy.
- R10: `tag_col` always equals `lk_col`, so the tag can be extended with it.
- R11: A write to one row leaves the fault words of all other rows unchanged.
- R12: `phys_col`, `row_dead` and `tag_col` follow `lk_row` and `lk_col` combinationally, within the same cycle and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Fault-word write enable from self-test |
| cfg_row | input | 8 | Row whose fault word is written |
| cfg_wdata | input | 4 | Fault word; bit i set means block i is faulty |
| lk_row | input | 8 | Row part of the access index |
| lk_col | input | 2 | Column part of the access index |
| phys_col | output | 2 | Rewritten column select for the column multiplexer |
| row_dead | output | 1 | Row has no healthy block |
| tag_col | output | 2 | Original column bits for tag extension |

## Verification
Lookup results are due in the same cycle as the row and column that drive them. The bench therefore drives a lookup and samples the three outputs 1 ns later, with no clock edge in between. A fault-word write takes effect at the next rising edge. Each write is followed by lookups at the next falling edge, and the one same-row check made before that edge expects the old word. Reset is likewise judged at the falling edge after the edge that applied it.

// File: rtl/col_remap_pkg.sv
// Package: col_remap_pkg
// Holds the default geometry of the remapper and a width helper.
// Assumes every count is a power of two where it is used as an address.
package col_remap_pkg;

    localparam int unsigned DEF_CACHE_BYTES = 32768;
    localparam int unsigned DEF_BLOCK_BYTES = 32;
    localparam int unsigned DEF_BLOCKS      = 4;

    // Bits needed to hold values 0..n (at least one bit)
    function automatic int unsigned bits_for(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/col_remap_store.sv
// Module: col_remap_store
// Holds one fault word per cache row. It has one synchronous write
// port and one combinational read port.
// Assumes: synchronous active-low reset clears all words (all blocks healthy);
// a read of the row being written returns the old word until the edge.
module col_remap_store #(
    parameter int unsigned ROWS   = 256,
    parameter int unsigned BLOCKS = 4,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [BLOCKS-1:0] wr_word,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [BLOCKS-1:0] rd_word
);

    logic [BLOCKS-1:0] words [ROWS];

    // Clear on reset, otherwise store the incoming fault word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                words[r] <= '0;
            end
        end else if (wr_en) begin
            words[wr_row] <= wr_word;
        end
    end

    // Same-cycle read of the addressed row
    always_comb begin
        rd_word = words[rd_row];
    end

endmodule

// File: rtl/col_remap_rank.sv
// Module: col_remap_rank
// For each block of a row, counts the faulty and the healthy blocks below
// it, and also the total number of healthy blocks in the row.
// Assumes: fault bit i set means block i is faulty.
module col_remap_rank #(
    parameter int unsigned BLOCKS = 4,
    localparam int unsigned CNT_W = col_remap_pkg::bits_for(BLOCKS)
) (
    input  logic [BLOCKS-1:0]       faults,
    output logic [BLOCKS*CNT_W-1:0] fault_below,
    output logic [BLOCKS*CNT_W-1:0] heal_below,
    output logic [CNT_W-1:0]        heal_total
);

    for (genvar i = 0; i < BLOCKS; i++) begin : g_blk
        logic [CNT_W-1:0] f_acc;
        logic [CNT_W-1:0] h_acc;

        // Prefix counts of faulty and healthy blocks under block i
        always_comb begin
            f_acc = '0;
            h_acc = '0;
            for (int j = 0; j < i; j++) begin
                f_acc = f_acc + CNT_W'(faults[j]);
                h_acc = h_acc + CNT_W'(!faults[j]);
            end
        end

        assign fault_below[i*CNT_W +: CNT_W] = f_acc;
        assign heal_below[i*CNT_W +: CNT_W]  = h_acc;
    end

    // Total healthy blocks in the row
    always_comb begin
        heal_total = '0;
        for (int j = 0; j < BLOCKS; j++) begin
            heal_total = heal_total + CNT_W'(!faults[j]);
        end
    end

endmodule

// File: rtl/col_remap_select.sv
// Module: col_remap_select
// Picks the physical column. A healthy block passes through unchanged.
// The k-th faulty block (ascending) takes the healthy block of rank
// k mod H, where H is the number of healthy blocks.
// A row with no healthy block is flagged, and its column passes through.
module col_remap_select #(
    parameter int unsigned BLOCKS = 4,
    localparam int unsigned COL_W = $clog2(BLOCKS),
    localparam int unsigned CNT_W = col_remap_pkg::bits_for(BLOCKS)
) (
    input  logic [COL_W-1:0]        col,
    input  logic [BLOCKS-1:0]       faults,
    input  logic [BLOCKS*CNT_W-1:0] fault_below,
    input  logic [BLOCKS*CNT_W-1:0] heal_below,
    input  logic [CNT_W-1:0]        heal_total,
    output logic [COL_W-1:0]        phys,
    output logic                    dead
);

    logic [CNT_W-1:0] my_rank;
    logic [CNT_W-1:0] target;

    // Rank of the requested block among the faulty ones
    always_comb begin
        my_rank = fault_below[int'(col)*CNT_W +: CNT_W];
    end

    // Wrap the rank onto the healthy set and search for the matching block
    always_comb begin
        dead   = (heal_total == '0);
        target = '0;
        phys   = col;
        if (!dead && faults[col]) begin
            target = my_rank % heal_total;
            for (int j = 0; j < BLOCKS; j++) begin
                if (!faults[j] && heal_below[j*CNT_W +: CNT_W] == target) begin
                    phys = COL_W'(j);
                end
            end
        end
    end

endmodule

// File: rtl/col_remap.sv
// Module: col_remap (top)
// Fault-aware column remapper for a direct-mapped cache. The row index
// reads a per-row fault word in the same cycle as the data array, and the
// column select is rewritten so that no faulty block is used.
// Assumes: BLOCKS is a power of two of at least 2; self-test loads fault
// words through the cfg_* port; all lookup outputs are combinational.
module col_remap
    import col_remap_pkg::*;
#(
    parameter int unsigned CACHE_BYTES = DEF_CACHE_BYTES,
    parameter int unsigned BLOCK_BYTES = DEF_BLOCK_BYTES,
    parameter int unsigned BLOCKS      = DEF_BLOCKS,
    localparam int unsigned ROWS  = CACHE_BYTES / (BLOCK_BYTES * BLOCKS),
    localparam int unsigned ROW_W = $clog2(ROWS),
    localparam int unsigned COL_W = $clog2(BLOCKS),
    localparam int unsigned CNT_W = bits_for(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [BLOCKS-1:0] cfg_wdata,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic [COL_W-1:0]  lk_col,
    output logic [COL_W-1:0]  phys_col,
    output logic              row_dead,
    output logic [COL_W-1:0]  tag_col
);

    logic [BLOCKS-1:0]       row_faults;
    logic [BLOCKS*CNT_W-1:0] fault_below;
    logic [BLOCKS*CNT_W-1:0] heal_below;
    logic [CNT_W-1:0]        heal_total;

    col_remap_store #(.ROWS(ROWS), .BLOCKS(BLOCKS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_row  (cfg_row),
        .wr_word (cfg_wdata),
        .rd_row  (lk_row),
        .rd_word (row_faults)
    );

    col_remap_rank #(.BLOCKS(BLOCKS)) u_rank (
        .faults      (row_faults),
        .fault_below (fault_below),
        .heal_below  (heal_below),
        .heal_total  (heal_total)
    );

    col_remap_select #(.BLOCKS(BLOCKS)) u_sel (
        .col         (lk_col),
        .faults      (row_faults),
        .fault_below (fault_below),
        .heal_below  (heal_below),
        .heal_total  (heal_total),
        .phys        (phys_col),
        .dead        (row_dead)
    );

    // Original column bits travel on to widen the tag
    assign tag_col = lk_col;

endmodule

// File: rtl/col_remap_checker.sv
// Module: col_remap_checker
// Property checks for col_remap, attached to it by a bind statement.
module col_remap_checker #(
    parameter int unsigned BLOCKS = 4,
    parameter int unsigned ROW_W  = 8,
    localparam int unsigned COL_W = $clog2(BLOCKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ROW_W-1:0]  cfg_row,
    input logic [BLOCKS-1:0] cfg_wdata,
    input logic [ROW_W-1:0]  lk_row,
    input logic [COL_W-1:0]  lk_col,
    input logic [COL_W-1:0]  phys_col,
    input logic              row_dead,
    input logic [BLOCKS-1:0] row_faults
);

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!row_dead && phys_col == lk_col));

    a_r2_healthy_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !row_faults[lk_col] |-> phys_col == lk_col);

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && lk_row == $past(cfg_row))
        |-> row_faults == $past(cfg_wdata));

    a_r8_dead_passes: assert property (@(posedge clk) disable iff (!rst_n)
        row_dead |-> (phys_col == lk_col && (&row_faults)));

    a_r9_pick_healthy: assert property (@(posedge clk) disable iff (!rst_n)
        !row_dead |-> !row_faults[phys_col]);

    a_r11_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lk_row == $past(lk_row) && lk_row != $past(cfg_row))
        |-> $stable(row_faults));

endmodule

bind col_remap col_remap_checker #(.BLOCKS(BLOCKS), .ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_row    (cfg_row),
    .cfg_wdata  (cfg_wdata),
    .lk_row     (lk_row),
    .lk_col     (lk_col),
    .phys_col   (phys_col),
    .row_dead   (row_dead),
    .row_faults (row_faults)
);

// File: tb/col_remap_test.sv
// Bench for col_remap: a table of fault words with the expected column
// map, followed by directed tests for reset, write timing and isolation.
module col_remap_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_row = '0;
    logic [3:0] cfg_wdata = '0;
    logic [7:0] lk_row = '0;
    logic [1:0] lk_col = '0;
    logic [1:0] phys_col;
    logic       row_dead;
    logic [1:0] tag_col;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    col_remap uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_row   (cfg_row),
        .cfg_wdata (cfg_wdata),
        .lk_row    (lk_row),
        .lk_col    (lk_col),
        .phys_col  (phys_col),
        .row_dead  (row_dead),
        .tag_col   (tag_col)
    );

    // Entry: {row[20:13], fault word[12:9], expected cols {c3,c2,c1,c0}[8:1], dead[0]}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {8'd5,   4'b0000, 8'b11_10_01_00, 1'b0},
        {8'd17,  4'b0100, 8'b11_00_01_00, 1'b0},
        {8'd40,  4'b0110, 8'b11_11_00_00, 1'b0},
        {8'd99,  4'b0111, 8'b11_11_11_11, 1'b0},
        {8'd200, 4'b1111, 8'b11_10_01_00, 1'b1},
        {8'd255, 4'b1001, 8'b10_10_01_01, 1'b0},
        {8'd0,   4'b1011, 8'b10_10_10_10, 1'b0},
        {8'd128, 4'b0101, 8'b11_11_01_01, 1'b0},
        {8'd77,  4'b1000, 8'b00_10_01_00, 1'b0},
        {8'd78,  4'b0001, 8'b11_10_01_01, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R2";
            1:       return "R5";
            2:       return "R6";
            3:       return "R7";
            4:       return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_row(input logic [7:0] r, input logic [3:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_row = r;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [7:0] r, input logic [1:0] c);
        lk_row = r;
        lk_col = c;
        #1;
    endtask

    // Check all four columns of one row against an expected map
    task automatic check_row(input string tag, input logic [7:0] r,
                             input logic [7:0] emap, input logic edead);
        for (int c = 0; c < 4; c++) begin
            look(r, 2'(c));
            chk(tag, int'(phys_col), int'(emap[c*2 +: 2]));
            chk({tag, " dead"}, int'(row_dead), int'(edead));
            chk("R10 tag", int'(tag_col), c);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: after reset every row is identity and not dead
        check_row("R1 reset", 8'd5, 8'b11_10_01_00, 1'b0);
        check_row("R1 reset", 8'd200, 8'b11_10_01_00, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            write_row(VEC[i][20:13], VEC[i][12:9]);
            check_row(vec_tag(i), VEC[i][20:13], VEC[i][8:1], VEC[i][0]);
        end

        // R3: same-cycle read of the row being written sees the old word
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_row = 8'd3;
        cfg_wdata = 4'b1111;
        look(8'd3, 2'd1);
        chk("R3 before edge dead", int'(row_dead), 0);
        chk("R3 before edge col", int'(phys_col), 1);
        @(negedge clk);
        cfg_we = 1'b0;
        look(8'd3, 2'd1);
        chk("R3 after edge dead", int'(row_dead), 1);

        // R11: writing row 18 leaves row 17 (block 2 faulty) intact
        write_row(8'd18, 4'b1111);
        check_row("R11 neighbour kept", 8'd17, 8'b11_00_01_00, 1'b0);

        // R12: outputs follow lookup inputs without a clock edge
        @(negedge clk);
        look(8'd40, 2'd2);
        chk("R12 comb first", int'(phys_col), 3);
        look(8'd40, 2'd1);
        chk("R12 comb second", int'(phys_col), 0);
        look(8'd200, 2'd1);
        chk("R12 comb dead", int'(row_dead), 1);

        // R1: a second reset clears the rows loaded above
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_row("R1 re-reset", 8'd40, 8'b11_10_01_00, 1'b0);
        check_row("R1 re-reset", 8'd200, 8'b11_10_01_00, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule